// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by walking a two-level table held in memory. The client hands over one virtual address on a valid/ready request channel. The walker captures the translation table base input at that moment and reads the first-level (directory) entry. If that entry is good, it reads the second-level (page) entry. It then returns one response holding either a physical address and a 4-bit domain index, or a fault code that names the level which failed, together with the virtual address it worked on.

Only one walk is in flight at a time. The request channel accepts only while the walker is idle. The response channel holds its payload unchanged until the client takes it. The memory read port sends one read at a time: the request is held until the memory accepts it, and the walker then waits for exactly one data beat, which it always accepts. The virtual address splits into a 12-bit directory index in bits 31:20, an 8-bit page index in bits 19:12 and a 12-bit byte offset in bits 11:0. Table entries are 4 bytes wide.

Top module: `xlate_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: `mem_req_valid` rises in the cycle after a request is accepted. The first read address is the captured base plus `req_vaddr[31:20]`×4, using the `tt_base` value seen in the accept cycle. Later changes to `tt_base` do not affect the walk.
- R3: A directory entry is usable only when its bits 1:0 equal 2'b01. For any other code (00, 10, 11) the walk ends after one read with `rsp_fault` = 2'b01. `rsp_fault` never shows 2'b11.
- R4: The second read address is the directory entry's bits 31:10 followed by ten zero bits, plus `req_vaddr[19:12]`×4. Directory bits 9:2 have no effect.
- R5: A page entry whose bit 1 is 0 ends the walk after two reads with `rsp_fault` = 2'b10. On any fault, `rsp_paddr` and `rsp_domain` are 0.
- R6: A page entry with bit 1 set gives `rsp_fault` = 2'b00, `rsp_paddr` = {entry[31:12], vaddr[11:0]} and `rsp_domain` = entry[7:4]. Entry bits 11:8, 3:2 and 0 have no effect.
- R7: `req_ready` is high only when no walk or response is pending. A raised `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response and its whole payload stay stable. After the response handshake, `rsp_valid` is low in the next cycle. `rsp_vaddr` equals the accepted request address.
- R9: At most one memory read is outstanding, and a walk issues no more than two reads: none while the data of the previous read is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tt_base | input | 32 | Physical base address of the directory |
| req_valid | input | 1 | Client presents a virtual address |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request pending |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data beat present (always accepted) |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_vaddr | output | 32 | Virtual address this result belongs to |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_domain | output | 4 | Domain index from the page entry (0 on fault) |
| rsp_fault | output | 2 | 00 success, 01 directory fault, 10 page fault |

## Verification
Two kinds of overlap are provoked on purpose. In the first, the finished response is stalled while the client already shows the next request. The bench holds `rsp_ready` low and drives `req_valid` with a different address, then judges that `req_ready` stays low and that every response field keeps its value until release. In the second, `tt_base` changes in the cycle right after the accept, while the first read is in flight. The read addresses logged by the bench's memory model must still come from the old base. Memory acceptance and read latency are varied across a sweep of directory and page indices. The sweep includes every invalid directory code, both index extremes and both fault levels.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // byte shift for 4-byte entries
  localparam int ENT_SH      = 2;
  // low bits below the next-level table pointer in a directory entry
  localparam int PTR_SH      = 10;
  // directory entry usable-code in bits [1:0]
  localparam logic [1:0] DIR_OK_CODE = 2'b01;
  // page entry valid flag position and domain field position
  localparam int PG_VLD_BIT  = 1;
  localparam int DOM_LSB     = 4;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_DIR  = 2'b01,
    FLT_PAGE = 2'b10
  } walk_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIR,
    ST_PAGE,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/entry_decode.sv
module entry_decode
  import xlate_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter int PTR_W   = 22,
  parameter int PBASE_W = 20,
  parameter int DOM_W   = 4
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic               dir_ok,
  output logic [PTR_W-1:0]   dir_ptr,
  output logic               page_ok,
  output logic [PBASE_W-1:0] page_base,
  output logic [DOM_W-1:0]   page_dom
);
  assign dir_ok    = (entry[1:0] == DIR_OK_CODE);
  assign dir_ptr   = entry[ENTRY_W-1 -: PTR_W];
  assign page_ok   = entry[PG_VLD_BIT];
  assign page_base = entry[ENTRY_W-1 -: PBASE_W];
  assign page_dom  = entry[DOM_LSB +: DOM_W];

  // reserved fields carry no meaning for the walk
  logic unused_rsv;
  assign unused_rsv = ^{entry[PTR_SH-1:2], entry[ENTRY_W-PBASE_W-1 : DOM_LSB+DOM_W], entry[3:2], entry[0]};
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
  import xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int DIR_IDX_W = 12,
  parameter int PT_IDX_W  = 8,
  parameter int PTR_W     = 22
) (
  input  logic             sel_page,
  input  logic [PA_W-1:0]  base,
  input  logic [VA_W-1:0]  va,
  input  logic [PTR_W-1:0] ptr,
  output logic [PA_W-1:0]  addr
);
  localparam int OFF_W = VA_W - DIR_IDX_W - PT_IDX_W;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [PT_IDX_W-1:0]  pt_idx;
  logic [PA_W-1:0]      dir_off, pt_off, tbl_base;

  assign dir_idx  = va[VA_W-1 -: DIR_IDX_W];
  assign pt_idx   = va[OFF_W +: PT_IDX_W];
  assign dir_off  = {{(PA_W-DIR_IDX_W-ENT_SH){1'b0}}, dir_idx, {ENT_SH{1'b0}}};
  assign pt_off   = {{(PA_W-PT_IDX_W-ENT_SH){1'b0}}, pt_idx, {ENT_SH{1'b0}}};
  assign tbl_base = {ptr, {(PA_W-PTR_W){1'b0}}};
  assign addr     = sel_page ? (tbl_base + pt_off) : (base + dir_off);

  logic unused_off;
  assign unused_off = ^va[OFF_W-1:0];
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PTR_W   = 22,
  parameter int PBASE_W = 20,
  parameter int DOM_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PA_W-1:0]    tt_base,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic               dir_ok,
  input  logic [PTR_W-1:0]   dir_ptr,
  input  logic               page_ok,
  input  logic [PBASE_W-1:0] page_base,
  input  logic [DOM_W-1:0]   page_dom,
  output logic               sel_page,
  output logic [VA_W-1:0]    cur_va,
  output logic [PA_W-1:0]    cur_base,
  output logic [PTR_W-1:0]   cur_ptr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [DOM_W-1:0]   rsp_domain,
  output logic [1:0]         rsp_fault
);
  localparam int OFF_W = PA_W - PBASE_W;

  walk_state_e state;
  walk_fault_e fault_q;
  logic        issued;
  logic [PA_W-1:0]  paddr_q;
  logic [DOM_W-1:0] dom_q;
  logic        fetching;

  assign fetching = (state == ST_DIR) || (state == ST_PAGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      issued   <= 1'b0;
      cur_va   <= '0;
      cur_base <= '0;
      cur_ptr  <= '0;
      paddr_q  <= '0;
      dom_q    <= '0;
      fault_q  <= FLT_NONE;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          cur_va   <= req_vaddr;
          cur_base <= tt_base;
          issued   <= 1'b0;
          state    <= ST_DIR;
        end
        ST_DIR, ST_PAGE: begin
          if (!issued) begin
            if (mem_req_ready) issued <= 1'b1;
          end else if (mem_rsp_valid) begin
            issued <= 1'b0;
            if (state == ST_DIR) begin
              if (dir_ok) begin
                cur_ptr <= dir_ptr;
                state   <= ST_PAGE;
              end else begin
                fault_q <= FLT_DIR;
                paddr_q <= '0;
                dom_q   <= '0;
                state   <= ST_DONE;
              end
            end else begin
              if (page_ok) begin
                fault_q <= FLT_NONE;
                paddr_q <= {page_base, cur_va[OFF_W-1:0]};
                dom_q   <= page_dom;
              end else begin
                fault_q <= FLT_PAGE;
                paddr_q <= '0;
                dom_q   <= '0;
              end
              state <= ST_DONE;
            end
          end
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = fetching && !issued;
  assign sel_page      = (state == ST_PAGE);
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_domain    = dom_q;
  assign rsp_fault     = fault_q;
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker #(
  parameter int VA_W      = 32,
  parameter int DIR_IDX_W = 12,
  parameter int PT_IDX_W  = 8,
  parameter int ENTRY_W   = 32,
  parameter int DOM_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRY_W-1:0] tt_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ENTRY_W-1:0] mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VA_W-1:0]    rsp_vaddr,
  output logic [ENTRY_W-1:0] rsp_paddr,
  output logic [DOM_W-1:0]   rsp_domain,
  output logic [1:0]         rsp_fault
);
  localparam int OFF_W   = VA_W - DIR_IDX_W - PT_IDX_W;
  localparam int PA_W    = ENTRY_W;
  localparam int PTR_W   = ENTRY_W - xlate_pkg::PTR_SH;
  localparam int PBASE_W = PA_W - OFF_W;

  logic               dir_ok, page_ok, sel_page;
  logic [PTR_W-1:0]   dir_ptr, cur_ptr;
  logic [PBASE_W-1:0] page_base;
  logic [DOM_W-1:0]   page_dom;
  logic [VA_W-1:0]    cur_va;
  logic [PA_W-1:0]    cur_base;

  entry_decode #(
    .ENTRY_W(ENTRY_W), .PTR_W(PTR_W), .PBASE_W(PBASE_W), .DOM_W(DOM_W)
  ) u_dec (
    .entry(mem_rsp_data), .dir_ok(dir_ok), .dir_ptr(dir_ptr),
    .page_ok(page_ok), .page_base(page_base), .page_dom(page_dom)
  );

  walk_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .PTR_W(PTR_W), .PBASE_W(PBASE_W), .DOM_W(DOM_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .tt_base(tt_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .dir_ok(dir_ok), .dir_ptr(dir_ptr), .page_ok(page_ok), .page_base(page_base), .page_dom(page_dom),
    .sel_page(sel_page), .cur_va(cur_va), .cur_base(cur_base), .cur_ptr(cur_ptr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_domain(rsp_domain), .rsp_fault(rsp_fault)
  );

  fetch_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .DIR_IDX_W(DIR_IDX_W), .PT_IDX_W(PT_IDX_W), .PTR_W(PTR_W)
  ) u_addr (
    .sel_page(sel_page), .base(cur_base), .va(cur_va), .ptr(cur_ptr), .addr(mem_req_addr)
  );

  assign rsp_vaddr = cur_va;
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int DOM_W   = 4,
  parameter int OFF_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [VA_W-1:0]  rsp_vaddr,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [DOM_W-1:0] rsp_domain,
  input logic [1:0]       rsp_fault
);
  logic       outst;
  logic [1:0] fetch_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst     <= 1'b0;
      fetch_cnt <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) outst <= 1'b1;
      else if (mem_rsp_valid)             outst <= 1'b0;
      if (req_valid && req_ready)               fetch_cnt <= '0;
      else if (mem_req_valid && mem_req_ready)  fetch_cnt <= fetch_cnt + 2'd1;
    end
  end

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                               && $stable(rsp_domain) && $stable(rsp_vaddr));

  assert_memreq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_idle_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !outst && !mem_req_valid);

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst && fetch_cnt < 2'd2);

  assert_fault_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'b00 |-> rsp_paddr == '0 && rsp_domain == '0);

  assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'b00 |-> rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]);
endmodule

bind xlate_walker xlate_walker_chk #(
  .VA_W(VA_W), .PA_W(ENTRY_W), .DOM_W(DOM_W), .OFF_W(VA_W - DIR_IDX_W - PT_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_vaddr(rsp_vaddr), .rsp_paddr(rsp_paddr), .rsp_domain(rsp_domain), .rsp_fault(rsp_fault)
);

// File: tb/tb_xlate_walker.sv
`timescale 1ns/1ps
module tb_xlate_walker;
  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0020_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tt_base = BASE_A;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_vaddr, rsp_paddr;
  logic [3:0]  rsp_domain;
  logic [1:0]  rsp_fault;

  always #4 clk = ~clk;

  xlate_walker dut (
    .clk(clk), .rst_n(rst_n), .tt_base(tt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_vaddr(rsp_vaddr),
    .rsp_paddr(rsp_paddr), .rsp_domain(rsp_domain), .rsp_fault(rsp_fault)
  );

  int n_chk = 0, n_pass = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act === exp) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory contents, computed
  function automatic logic [31:0] dir_entry(input int idx);
    logic [1:0] code;
    if (idx % 5 == 0) begin
      case ((idx / 5) % 3)
        0: code = 2'b00;
        1: code = 2'b10;
        default: code = 2'b11;
      endcase
      return {22'h2AAAAA ^ 22'(idx), 8'(idx * 3), code};
    end
    return {22'h200000 + 22'(idx * 2), 8'(idx ^ 8'hC3), 2'b01};
  endfunction

  function automatic logic [31:0] page_entry(input int t, input int p);
    if ((t + p) % 4 == 0) return {20'(t * 5 + p), 4'hF, 4'(t), 2'b11, 1'b0, 1'b1};
    return {20'(t * 37 + p * 11) ^ 20'h5A5A5, 4'(p), 4'(t ^ p), 2'(p), 1'b1, 1'(t)};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a >= BASE_A && a < BASE_A + 32'h4000) return dir_entry(int'((a - BASE_A) >> 2));
    if (a >= BASE_B && a < BASE_B + 32'h4000) return dir_entry(int'((a - BASE_B) >> 2) ^ 1);
    if (a >= 32'h8000_0000) return page_entry(int'((a - 32'h8000_0000) >> 11), int'((a >> 2) & 32'hFF));
    return 32'h0BAD_F00C;
  endfunction

  // memory model: acts on falling edges
  int          lat = 1, ready_mode = 0, cyc = 0, mcnt = 0;
  bit          mbusy = 1'b0;
  logic [31:0] maddr;
  logic [31:0] log_addr [4];
  int          log_n = 0;

  always @(negedge clk) begin
    cyc++;
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (mbusy) begin
      mcnt--;
      if (mcnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(maddr);
        mbusy = 1'b0;
      end
    end
    mem_req_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
    if (rst_n && !mbusy && mem_req_valid && mem_req_ready) begin
      if (log_n < 4) log_addr[log_n] = mem_req_addr;
      log_n++;
      maddr = mem_req_addr;
      mbusy = 1'b1;
      mcnt  = lat;
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [31:0] base, input int stall, input bit swap);
    logic [31:0] d_addr, d, p_addr, p, e_pa;
    logic [3:0]  e_dom;
    logic [1:0]  e_flt;
    int          e_n;
    logic [31:0] h_pa, h_va;
    logic [3:0]  h_dom;
    logic [1:0]  h_flt;
    d_addr = base + {18'b0, va[31:20], 2'b00};
    d      = mem_word(d_addr);
    p_addr = '0;
    if (d[1:0] != 2'b01) begin
      e_flt = 2'b01; e_pa = '0; e_dom = '0; e_n = 1;
    end else begin
      p_addr = {d[31:10], 10'b0} + {22'b0, va[19:12], 2'b00};
      p = mem_word(p_addr);
      e_n = 2;
      if (!p[1]) begin e_flt = 2'b10; e_pa = '0; e_dom = '0; end
      else begin e_flt = 2'b00; e_pa = {p[31:12], va[11:0]}; e_dom = p[7:4]; end
    end
    log_n = 0;
    tt_base = base;
    req_vaddr = va;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (swap) tt_base = (base == BASE_A) ? BASE_B : BASE_A;
    chk("R2", "mem_req_valid after accept", 32'(mem_req_valid), 32'd1);
    while (!rsp_valid) @(negedge clk);
    h_pa = rsp_paddr; h_va = rsp_vaddr; h_dom = rsp_domain; h_flt = rsp_fault;
    for (int i = 0; i < stall; i++) begin
      req_valid = 1'b1;
      req_vaddr = ~va;
      @(negedge clk);
      chk("R7", "req_ready while response pending", 32'(req_ready), 32'd0);
      chk("R8", "rsp_valid held", 32'(rsp_valid), 32'd1);
      chk("R8", "payload held", {rsp_paddr ^ h_pa} | {28'b0, rsp_domain ^ h_dom} | {30'b0, rsp_fault ^ h_flt}
                                | (rsp_vaddr ^ h_va), 32'd0);
    end
    req_valid = 1'b0;
    req_vaddr = va;
    rsp_ready = 1'b1;
    if (e_flt == 2'b01)      chk("R3", "directory fault code", 32'(rsp_fault), 32'(e_flt));
    else if (e_flt == 2'b10) chk("R5", "page fault code", 32'(rsp_fault), 32'(e_flt));
    else                     chk("R6", "success code", 32'(rsp_fault), 32'(e_flt));
    chk(e_flt == 2'b00 ? "R6" : "R5", "rsp_paddr", rsp_paddr, e_pa);
    chk(e_flt == 2'b00 ? "R6" : "R5", "rsp_domain", 32'(rsp_domain), 32'(e_dom));
    chk("R8", "rsp_vaddr", rsp_vaddr, va);
    chk("R9", "read count", 32'(log_n), 32'(e_n));
    chk("R2", "directory read address", log_addr[0], d_addr);
    if (e_n == 2) chk("R4", "page read address", log_addr[1], p_addr);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8", "rsp_valid after handshake", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset", 32'(req_ready), 32'd1);
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R1", "mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    begin
      int n = 0;
      int pl [6] = '{0, 1, 2, 3, 128, 255};
      for (int di = 0; di < 64; di++) begin
        for (int k = 0; k < 6; k++) begin
          logic [31:0] va;
          va = {12'(di), 8'(pl[k]), 12'((di * 97 + pl[k] * 13) & 32'hFFF)};
          lat = 1 + (n % 3);
          ready_mode = n % 2;
          run_walk(va, (n % 7 == 3) ? BASE_B : BASE_A, n % 4, (n % 5 == 1));
          n++;
        end
      end
    end
    // index extremes
    lat = 2; ready_mode = 1;
    run_walk(32'hFFFF_FFFF, BASE_A, 1, 1'b0);
    run_walk(32'hFFEF_FFFF, BASE_A, 2, 1'b1);
    run_walk(32'hFFEF_F000, BASE_B, 0, 1'b1);
    lat = 1; ready_mode = 0;
    run_walk(32'h0010_0000, BASE_A, 0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual=hung expected=walk completes");
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  end
endmodule